// File: doc/BRIEF.md
# Aliased FIFO Register Window

This block is the host-facing register interface of a communications controller that buffers traffic in two byte FIFOs: one filled by the line and drained by the host (receive), and one filled by the host and drained by the line (transmit). Both FIFOs sit behind a single 32-byte address window. A host read anywhere in that window takes the oldest receive byte, and a host write anywhere in it appends to the transmit FIFO. The direction of the access therefore acts as one more address bit. Because the low address bits are ignored inside the window, an autoincrementing 32-byte block copy moves 32 FIFO entries.

A small status group sits above the window and reports both fill levels and two sticky error flags. The error flags are cleared when they are read. For hosts with a narrow address space there is also an indirect path with two ports. The host writes an internal address into a latch on port 0. Every later access to port 1 is then routed to that latched address. The latch keeps its value, so pointing it at the window once lets the host stream a whole FIFO through one port. On the line side, both directions are plain valid/ready byte streams.

Top module: `fwin_top`

## Requirements
- R1: A host read strobe (host_cs=1, host_we=0) at a FIFO-window address removes the oldest receive byte. That byte appears on host_rdata after the clock edge that ends the strobe cycle, and host_rdata holds its value until the next read.
- R2: A host write strobe at a FIFO-window address appends host_wdata to the transmit FIFO. The receive FIFO is left untouched, even though it shares the same address.
- R3: Each FIFO hands its bytes out in exactly the order they went in.
- R4: The FIFO window is direct addresses 0x00 to 0x1F. Address bits [4:0] are ignored inside it, so a sweep over all 32 addresses reaches the same FIFO 32 times.
- R5: When host_ind=1, host_addr[0]=0 selects the address latch and host_addr[0]=1 selects the data port. The other address bits are ignored. A write to the latch port loads the latch, and a read of the latch port returns the latch. A data-port access behaves exactly like a direct access at the latched address.
- R6: Data-port accesses never change the latch, so repeated data-port reads or writes keep popping or pushing the FIFO.
- R7: A read of an empty receive FIFO returns 0x00, removes nothing, and sets the sticky underflow flag (bit 0 of the flag register).
- R8: A write to a full transmit FIFO (32 entries) is dropped and sets the sticky overflow flag (bit 1 of the flag register).
- R9: Address 0x20 reads the receive count and 0x21 reads the transmit count, each from 0 to 32. Address 0x22 reads the flags and clears them in the same access; if a new error happens in that same cycle, its flag stays set. All other addresses outside the window read 0x00.
- R10: A FIFO pops or pushes only in a cycle where host_cs=1. With host_cs low, address and direction have no effect.
- R11: rx_ready is high while the receive FIFO holds fewer than 32 bytes, and a byte is taken when rx_valid and rx_ready are both high. tx_valid is high while the transmit FIFO is non-empty, with tx_data showing the oldest byte. That byte leaves when tx_ready is high.
- R12: After reset, both FIFOs are empty, the flags are clear, the latch is 0x00 and host_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ind | input | 1 | 1 = indirect two-port path, 0 = direct address |
| host_addr | input | 8 | Direct address, or port select in bit 0 when indirect |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| rx_valid | input | 1 | Line receive byte valid |
| rx_data | input | 8 | Line receive byte |
| rx_ready | output | 1 | Receive FIFO has room |
| tx_valid | output | 1 | Transmit FIFO non-empty |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Line accepts the transmit byte |

## Verification
Read data is registered, so a read value is due one edge after the strobe cycle. Each host access is driven on a falling edge, and host_rdata is sampled on the following falling edge, after the capturing rising edge. Pushes, pops, count changes and flag updates take effect at that same rising edge. The bench therefore reads the counts and flags back through a later status access, not by looking at internal state. tx_valid and tx_data follow the transmit FIFO head directly, so they are checked on the falling edge after the push or pop edge, and the line handshakes use the same edge discipline.

// File: rtl/fwin_pkg.sv
// Package: shared types and constants for the aliased FIFO register window.
// Assumes an 8-bit host address space with the FIFO window at the bottom.
package fwin_pkg;

    // Access target produced by the address decoder.
    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_FIFO  = 3'd1,
        TGT_RXCNT = 3'd2,
        TGT_TXCNT = 3'd3,
        TGT_FLAGS = 3'd4,
        TGT_LATCH = 3'd5
    } fwin_tgt_e;

    // Bit positions inside the sticky flag register.
    localparam int FLAG_UDF_BIT = 0;
    localparam int FLAG_OVF_BIT = 1;
    localparam int FLAG_W       = 2;

endpackage

// File: rtl/fwin_fifo.sv
// Module: fwin_fifo
// Single-clock byte FIFO with a combinational head output and a fill count.
// Assumes the caller gates push with !full and pop with !empty; requests
// outside those conditions are ignored here as a second line of defence.
module fwin_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Qualify requests against the current fill state.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Storage write: one entry per accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and count update, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Status and head outputs.
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
        head  = mem[rd_ptr];
    end

endmodule

// File: rtl/fwin_access.sv
// Module: fwin_access
// Host access decoder with the indirect address latch.
// Direct accesses decode host_addr; indirect accesses use bit 0 to pick the
// latch port or the data port, and the data port decodes the latched address.
// Assumes ADDR_W <= DATA_W so the latch can be loaded from write data.
module fwin_access
    import fwin_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int WIN_LOG2  = 5,
    parameter int STAT_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_ind,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] latch_q,
    output fwin_tgt_e         tgt
);

    localparam int HI_W = ADDR_W - WIN_LOG2;

    logic [ADDR_W-1:0] eff_addr;
    logic              latch_port;

    // Select the effective internal address for this access.
    always_comb begin
        latch_port = host_ind && !host_addr[0];
        eff_addr   = host_ind ? latch_q : host_addr;
    end

    // Map the effective address to a target.
    always_comb begin
        if (latch_port) begin
            tgt = TGT_LATCH;
        end else if (eff_addr[ADDR_W-1:WIN_LOG2] == HI_W'(0)) begin
            tgt = TGT_FIFO;
        end else if (eff_addr == ADDR_W'(STAT_BASE)) begin
            tgt = TGT_RXCNT;
        end else if (eff_addr == ADDR_W'(STAT_BASE + 1)) begin
            tgt = TGT_TXCNT;
        end else if (eff_addr == ADDR_W'(STAT_BASE + 2)) begin
            tgt = TGT_FLAGS;
        end else begin
            tgt = TGT_NONE;
        end
    end

    // Address latch: loaded only by a write strobe on the latch port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (host_cs && host_we && latch_port) begin
            latch_q <= host_wdata[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/fwin_flags.sv
// Module: fwin_flags
// Sticky error flags. A clear request and a new error in the same cycle
// leave that error's flag set, so no event is lost across a status read.
module fwin_flags
    import fwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_udf,
    input  logic              set_ovf,
    input  logic              clr,
    output logic [FLAG_W-1:0] flags
);

    // Set-dominant sticky update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags[FLAG_UDF_BIT] <= set_udf || (flags[FLAG_UDF_BIT] && !clr);
            flags[FLAG_OVF_BIT] <= set_ovf || (flags[FLAG_OVF_BIT] && !clr);
        end
    end

endmodule

// File: rtl/fwin_top.sv
// Module: fwin_top
// Aliased FIFO register window. Host reads in the window drain the receive
// FIFO, host writes fill the transmit FIFO, status registers sit above the
// window, and an indirect latch/data port pair gives two-port access.
// Assumes one host access per strobe cycle; read data is registered.
module fwin_top
    import fwin_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int DEPTH     = 32,
    parameter int WIN_LOG2  = 5,
    parameter int STAT_BASE = 32,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_ind,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready
);

    fwin_tgt_e         tgt;
    logic [ADDR_W-1:0] ind_latch;
    logic [DATA_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_cnt;
    logic [CNT_W-1:0]  tx_cnt;
    logic              rx_empty, rx_full;
    logic              tx_empty, tx_full;
    logic              fifo_rd, fifo_wr;
    logic              rx_pop, tx_push;
    logic              line_push, line_pop;
    logic              flags_clr;
    logic [FLAG_W-1:0] flags;

    fwin_access #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WIN_LOG2 (WIN_LOG2),
        .STAT_BASE(STAT_BASE)
    ) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_cs   (host_cs),
        .host_we   (host_we),
        .host_ind  (host_ind),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .latch_q   (ind_latch),
        .tgt       (tgt)
    );

    // Strobe-qualified FIFO requests from the host and the line.
    always_comb begin
        fifo_rd   = host_cs && !host_we && (tgt == TGT_FIFO);
        fifo_wr   = host_cs && host_we && (tgt == TGT_FIFO);
        rx_pop    = fifo_rd && !rx_empty;
        tx_push   = fifo_wr && !tx_full;
        line_push = rx_valid && !rx_full;
        line_pop  = tx_ready && !tx_empty;
        flags_clr = host_cs && !host_we && (tgt == TGT_FLAGS);
    end

    fwin_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (line_push),
        .push_data(rx_data),
        .pop      (rx_pop),
        .head     (rx_head),
        .count    (rx_cnt),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    fwin_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_push),
        .push_data(host_wdata),
        .pop      (line_pop),
        .head     (tx_data),
        .count    (tx_cnt),
        .empty    (tx_empty),
        .full     (tx_full)
    );

    fwin_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_udf(fifo_rd && rx_empty),
        .set_ovf(fifo_wr && tx_full),
        .clr    (flags_clr),
        .flags  (flags)
    );

    // Line-side handshake outputs.
    always_comb begin
        rx_ready = !rx_full;
        tx_valid = !tx_empty;
    end

    // Registered read data, captured on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_cs && !host_we) begin
            case (tgt)
                TGT_FIFO:  host_rdata <= rx_empty ? '0 : rx_head;
                TGT_RXCNT: host_rdata <= DATA_W'(rx_cnt);
                TGT_TXCNT: host_rdata <= DATA_W'(tx_cnt);
                TGT_FLAGS: host_rdata <= DATA_W'(flags);
                TGT_LATCH: host_rdata <= DATA_W'(ind_latch);
                default:   host_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/fwin_checker.sv
// Module: fwin_checker
// Property checks for fwin_top, attached with the bind below.
// Assumes it sees the top's counts, flags and latch through bind connections.
module fwin_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_we,
    input logic              host_ind,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic              fifo_rd,
    input logic              fifo_wr,
    input logic [1:0]        flags,
    input logic [ADDR_W-1:0] ind_latch
);

    // R10: no host strobe, so the receive count can only grow.
    a_r10_no_rx_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |=> (rx_cnt >= $past(rx_cnt)));

    // R10: no host strobe, so the transmit count can only shrink.
    a_r10_no_tx_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |=> (tx_cnt <= $past(tx_cnt)));

    // R7: an empty read returns zero and raises underflow.
    a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && rx_cnt == '0) |=> (host_rdata == '0 && flags[0]));

    // R8: a write to a full FIFO raises overflow and adds nothing.
    a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && tx_cnt == CNT_W'(DEPTH)) |=> (flags[1] && tx_cnt <= CNT_W'(DEPTH)));

    // R6: data-port accesses leave the latch untouched.
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_ind && host_addr[0]) |=> (ind_latch == $past(ind_latch)));

    // R11: handshakes agree with the fill levels.
    a_r11_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready == (rx_cnt < CNT_W'(DEPTH))) && (tx_valid == (tx_cnt != '0)));

    // R11: counts never exceed the depth.
    a_r11_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH) && tx_cnt <= CNT_W'(DEPTH));

    // R11: a line push with no host pop raises the receive count by one.
    a_r11_rx_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !host_cs) |=> (rx_cnt == $past(rx_cnt) + 1'b1));

    // R11: a line pop with no host push lowers the transmit count by one.
    a_r11_tx_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid && !host_cs) |=> (tx_cnt == $past(tx_cnt) - 1'b1));

endmodule

bind fwin_top fwin_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_fwin_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cs   (host_cs),
    .host_we   (host_we),
    .host_ind  (host_ind),
    .host_addr (host_addr),
    .host_rdata(host_rdata),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .rx_cnt    (rx_cnt),
    .tx_cnt    (tx_cnt),
    .fifo_rd   (fifo_rd),
    .fifo_wr   (fifo_wr),
    .flags     (flags),
    .ind_latch (ind_latch)
);

// File: tb/tb_fwin_top.sv
// Bench for fwin_top: sweeps the window, status registers and indirect path
// with expected values computed arithmetically.
module tb_fwin_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_we = 1'b0, host_ind = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwin_top dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_we(host_we), .host_ind(host_ind),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One host access; starts and ends on a falling edge.
    task automatic host(input bit ind, input bit we, input logic [7:0] a,
                        input logic [7:0] d, output logic [7:0] q);
        host_ind = ind; host_we = we; host_addr = a; host_wdata = d;
        host_cs = 1'b1;
        @(posedge clk); @(negedge clk);
        host_cs = 1'b0;
        q = host_rdata;
    endtask

    task automatic line_push(input logic [7:0] d);
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic line_pop(input string req, input logic [7:0] exp);
        check(req, int'(tx_valid), 1);
        check(req, int'(tx_data), int'(exp));
        tx_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 rdata", int'(host_rdata), 0);
        check("R12 tx_valid", int'(tx_valid), 0);
        check("R12 rx_ready", int'(rx_ready), 1);
        host(0, 0, 8'h20, 0, q); check("R12 rx count", q, 0);
        host(0, 0, 8'h21, 0, q); check("R12 tx count", q, 0);
        host(0, 0, 8'h22, 0, q); check("R12 flags", q, 0);
        host(1, 0, 8'h00, 0, q); check("R12 latch", q, 0);

        // R11: fill receive FIFO from the line
        for (int i = 0; i < 32; i++) line_push(8'((i * 7 + 3) & 8'hff));
        check("R11 rx_ready full", int'(rx_ready), 0);
        line_push(8'hEE);
        host(0, 0, 8'h20, 0, q); check("R11 R9 rx count full", q, 32);

        // R10: idle address/direction without strobe
        host_addr = 8'h05; host_we = 1'b0; host_ind = 1'b0;
        repeat (3) @(negedge clk);
        host_we = 1'b1; host_wdata = 8'h99;
        repeat (3) @(negedge clk);
        host(0, 0, 8'h20, 0, q); check("R10 rx count unchanged", q, 32);
        host(0, 0, 8'h21, 0, q); check("R10 tx count unchanged", q, 0);

        // R1 R3 R4: incrementing sweep drains in order
        for (int a = 0; a < 32; a++) begin
            host(0, 0, 8'(a), 0, q);
            check("R1 R3 R4 window read", q, (a * 7 + 3) & 8'hff);
        end
        check("R11 rx_ready after drain", int'(rx_ready), 1);

        // R7 R9: empty read, flag read clears
        host(0, 0, 8'h1F, 0, q); check("R7 empty read", q, 0);
        host(0, 0, 8'h20, 0, q); check("R7 no pop", q, 0);
        host(0, 0, 8'h22, 0, q); check("R7 R9 underflow flag", q, 1);
        host(0, 0, 8'h22, 0, q); check("R9 flags cleared", q, 0);

        // R2 R4 R8: write sweep fills transmit FIFO
        for (int a = 0; a < 32; a++) host(0, 1, 8'(a), 8'((a * 5 + 1) & 8'hff), q);
        host(0, 0, 8'h20, 0, q); check("R2 rx untouched", q, 0);
        host(0, 0, 8'h21, 0, q); check("R2 R9 tx count", q, 32);
        host(0, 1, 8'h10, 8'hAA, q);
        host(0, 0, 8'h21, 0, q); check("R8 tx count held", q, 32);
        host(0, 0, 8'h22, 0, q); check("R8 overflow flag", q, 2);
        for (int i = 0; i < 32; i++) line_pop("R3 R11 tx order", 8'((i * 5 + 1) & 8'hff));
        check("R11 tx_valid empty", int'(tx_valid), 0);

        // R9: unmapped and status region
        host(0, 0, 8'h23, 0, q); check("R9 unmapped 0x23", q, 0);
        host(0, 0, 8'h80, 0, q); check("R9 unmapped 0x80", q, 0);
        host(0, 0, 8'hFF, 0, q); check("R9 unmapped 0xFF", q, 0);

        // R5 R6: indirect streaming of receive data
        host(1, 1, 8'h00, 8'h07, q);
        host(1, 0, 8'hFE, 0, q); check("R5 latch readback", q, 8'h07);
        for (int i = 0; i < 10; i++) line_push(8'(8'h40 + i));
        for (int i = 0; i < 10; i++) begin
            host(1, 0, 8'h01, 0, q);
            check("R6 data port stream", q, 8'h40 + i);
        end
        host(1, 0, 8'h00, 0, q); check("R6 latch kept", q, 8'h07);

        // R5: data port routed to status registers
        host(1, 1, 8'h00, 8'h22, q);
        host(1, 0, 8'h01, 0, q); check("R5 indirect flags", q, 0);
        host(1, 0, 8'h03, 0, q); check("R5 data port, upper bits ignored", q, 0);
        host(1, 1, 8'h02, 8'h15, q);
        host(1, 0, 8'h00, 0, q); check("R5 latch port, upper bits ignored", q, 8'h15);
        for (int i = 0; i < 5; i++) host(1, 1, 8'h01, 8'(8'hC0 + i), q);
        host(0, 0, 8'h21, 0, q); check("R6 indirect tx count", q, 5);
        for (int i = 0; i < 5; i++) line_pop("R6 R3 indirect tx order", 8'(8'hC0 + i));

        // R4: every window address aliases, addresses above do not
        for (int a = 0; a < 64; a++) begin
            line_push(8'(a + 1));
            host(0, 0, 8'(a), 0, q);
            if (a < 32) check("R4 alias read", q, a + 1);
            else if (a == 32) check("R4 R9 count not fifo", q, 1);
            else if (a == 33 || a == 34) check("R4 R9 status", q, 0);
            else check("R4 R9 outside window", q, 0);
            if (a >= 32) host(0, 0, 8'h00, 0, q);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule